// File: doc/BRIEF.md
# Double-Pulse Reset Sequencer

This block produces a reset signal for downstream logic that needs to be reset twice in a row. A one-cycle start strobe begins a sequence. The output is held low for a short settling period first. It is then driven high for a pulse of N clock cycles, low for a gap of N cycles, and high again for N cycles. A short low tail follows, and the block then reports completion with a one-cycle done pulse.

The pulse width N is taken from a count input when the start is accepted. Any request below a fixed floor is raised to that floor. The sequencer has its own asynchronous active-low reset, which is released synchronously inside the block. The generated reset is a registered output in the sequencer's clock domain. Any crossing of that reset into other domains is left to the receiving logic.

Top module: `dbl_rst_seq`

## Requirements
- R1: While `rst_n` is low, `rst_o`, `busy_o` and `done_o` are all 0.
- R2: A start strobe sampled high at a clock edge while idle is accepted at that edge. From the next cycle `busy_o` is 1, and `rst_o` stays 0 for the first 10 cycles of the sequence.
- R3: After the settling period, `rst_o` is 1 for N cycles, then 0 for N cycles, then 1 for another N cycles.
- R4: N equals `width_i` read as an unsigned 16-bit number, except that any value below 110 is replaced by 110. The default floor is 110 cycles, which is 440 ns at 250 MHz.
- R5: After the second high pulse, `rst_o` is 0 for 5 cycles. In the cycle after those 5 cycles, `done_o` is 1 for exactly one cycle and `busy_o` is 0 in that same cycle.
- R6: A start strobe that arrives while a sequence is running has no effect on its timing or on its width.
- R7: `width_i` is captured only when a start is accepted. Changing it during a running sequence has no effect.
- R8: A start strobe given in the cycle in which `done_o` is high is accepted, and a new sequence with the R2 timing follows directly.
- R9: Pulling `rst_n` low during a sequence drops `rst_o` and `busy_o` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| start_i | input | 1 | Start request, sampled on the rising clock edge |
| width_i | input | 16 | Requested pulse and gap length in cycles |
| rst_o | output | 1 | Generated double-pulse reset, active high |
| busy_o | output | 1 | High while a sequence is running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every output of the block is a register. Taking the edge that accepts the start as edge 0, each result becomes visible after the k-th edge that follows it:
- `busy_o` rises after edge 0.
- `rst_o` rises after edge 10 and falls after edge 10+N.
- `rst_o` rises again after edge 10+2N and falls after edge 10+3N.
- `done_o` appears after edge 15+3N, and `busy_o` falls on that same edge.

The bench drives its inputs on falling edges and compares all three outputs on every falling edge against this schedule, which it computes from the requested width. It therefore catches a timing error of a single cycle in any phase.

// File: rtl/dbl_rst_pkg.sv
package dbl_rst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_HIGH1 = 3'd2,
    ST_GAP   = 3'd3,
    ST_HIGH2 = 3'd4,
    ST_TAIL  = 3'd5
  } seq_state_e;

endpackage

// File: rtl/drs_reset_sync.sv
// Asynchronous assertion, synchronous release of the sequencer's own reset.
module drs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/drs_width_floor.sv
// Raises a requested cycle count to a minimum.
module drs_width_floor #(
  parameter int CNT_W     = 16,
  parameter int MIN_WIDTH = 110
) (
  input  logic [CNT_W-1:0] req_i,
  output logic [CNT_W-1:0] eff_o
);

  localparam logic [CNT_W-1:0] MinVal = CNT_W'(MIN_WIDTH);

  always_comb begin
    if (req_i < MinVal) begin
      eff_o = MinVal;
    end else begin
      eff_o = req_i;
    end
  end

endmodule

// File: rtl/drs_down_counter.sv
// Loadable down-counter that holds at zero.
module drs_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (zero_o == ($past(load_val_i) == '0)));  // R3

endmodule

// File: rtl/drs_seq_fsm.sv
// Phase sequencing for the double-pulse reset.
module drs_seq_fsm
  import dbl_rst_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_CYC  = 10,
  parameter int TAIL_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] width_eff_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cnt_en_o,
  output logic             rst_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] PreLoad  = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] TailLoad = CNT_W'(TAIL_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] width_q, width_d;
  logic             width_en;
  logic             rst_q, busy_q, done_q;
  logic             rst_d, busy_d, done_d;

  // Next-state and counter control
  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    width_en   = 1'b0;
    width_d    = width_q;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_PRE;
          cnt_load_o = 1'b1;
          cnt_val_o  = PreLoad;
          width_en   = 1'b1;
          width_d    = width_eff_i;
        end
      end
      ST_PRE: begin
        if (cnt_zero_i) begin
          state_d    = ST_HIGH1;
          cnt_load_o = 1'b1;
          cnt_val_o  = width_q - 1'b1;
        end
      end
      ST_HIGH1: begin
        if (cnt_zero_i) begin
          state_d    = ST_GAP;
          cnt_load_o = 1'b1;
          cnt_val_o  = width_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_zero_i) begin
          state_d    = ST_HIGH2;
          cnt_load_o = 1'b1;
          cnt_val_o  = width_q - 1'b1;
        end
      end
      ST_HIGH2: begin
        if (cnt_zero_i) begin
          state_d    = ST_TAIL;
          cnt_load_o = 1'b1;
          cnt_val_o  = TailLoad;
        end
      end
      ST_TAIL: begin
        if (cnt_zero_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    rst_d  = (state_d == ST_HIGH1) || (state_d == ST_HIGH2);
    busy_d = (state_d != ST_IDLE);
  end

  assign cnt_en_o = (state_q != ST_IDLE);

  // State and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rst_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  // Captured width, clock-enabled on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
    end else if (width_en) begin
      width_q <= width_d;
    end
  end

  assign rst_o  = rst_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_PRE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |-> !rst_o);  // R2
  AST_RST_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> busy_o);  // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);  // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (state_q != ST_IDLE) && (state_q != ST_PRE)) |=> (state_q != ST_PRE));  // R6
  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(width_q));  // R7

endmodule

// File: rtl/dbl_rst_seq.sv
module dbl_rst_seq #(
  parameter int CNT_W      = 16,
  parameter int MIN_WIDTH  = 110,
  parameter int PRE_CYC    = 10,
  parameter int TAIL_CYC   = 5,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             rst_o,
  output logic             busy_o,
  output logic             done_o
);

  logic             srst_n;
  logic [CNT_W-1:0] width_eff;
  logic             cnt_load, cnt_en, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  drs_reset_sync #(.STAGES(SYNC_STAGE)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  drs_width_floor #(.CNT_W(CNT_W), .MIN_WIDTH(MIN_WIDTH)) u_floor (
    .req_i (width_i),
    .eff_o (width_eff)
  );

  drs_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (srst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .en_i       (cnt_en),
    .zero_o     (cnt_zero)
  );

  drs_seq_fsm #(.CNT_W(CNT_W), .PRE_CYC(PRE_CYC), .TAIL_CYC(TAIL_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (srst_n),
    .start_i     (start_i),
    .width_eff_i (width_eff),
    .cnt_zero_i  (cnt_zero),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val),
    .cnt_en_o    (cnt_en),
    .rst_o       (rst_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: tb/dbl_rst_seq_bench.sv
module dbl_rst_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] width_i;
  logic        rst_o, busy_o, done_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam int NVEC = 6;
  localparam int VEC_REQ[NVEC] = '{0, 50, 109, 110, 111, 160};
  localparam int VEC_EFF[NVEC] = '{110, 110, 110, 110, 111, 160};

  dbl_rst_seq u_dbl_rst_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .width_i (width_i),
    .rst_o   (rst_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check3(input string req, input logic r, input logic b, input logic d,
                        input logic er, input logic eb, input logic ed);
    checks++;
    if (r !== er || b !== eb || d !== ed) begin
      failures++;
      $display("FAIL %s rst/busy/done actual=%b%b%b expected=%b%b%b at %0t",
               req, r, b, d, er, eb, ed, $time);
    end
  endtask

  // One full sequence, checked cycle by cycle. k counts falling edges after the accepting edge.
  task automatic run_seq(input int req, input int eff, input int inj_k, input bit chain,
                         input bit skip_start, input string tag);
    if (!skip_start) begin
      @(negedge clk);
      start_i = 1'b1;
      width_i = 16'(req);
    end
    @(negedge clk);
    start_i = 1'b0;
    width_i = 16'd3;
    for (int k = 0; k <= 16 + 3 * eff; k++) begin
      logic er, eb, ed;
      string phase;
      er = ((k >= 10) && (k < 10 + eff)) || ((k >= 10 + 2 * eff) && (k < 10 + 3 * eff));
      eb = (k < 15 + 3 * eff);
      ed = (k == 15 + 3 * eff);
      if (k < 10) phase = "R2";
      else if (k < 10 + 3 * eff) phase = "R3/R4";
      else phase = "R5";
      check3({tag, " ", phase}, rst_o, busy_o, done_o, er, eb, ed);
      if (chain && k == 15 + 3 * eff) begin
        start_i = 1'b1;       // R8 start in the done cycle
        width_i = 16'(req);
        return;
      end
      if (k == inj_k) begin
        start_i = 1'b1;       // R6 start while busy
        width_i = 16'd300;
      end else begin
        start_i = 1'b0;
        width_i = (k % 2 == 0) ? 16'd400 : 16'd3;  // R7 width moves while running
      end
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    width_i = '0;
    repeat (3) @(negedge clk);
    check3("R1", rst_o, busy_o, done_o, 1'b0, 1'b0, 1'b0);
    start_i = 1'b1;
    @(negedge clk);
    check3("R1 start held in reset", rst_o, busy_o, done_o, 1'b0, 1'b0, 1'b0);
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check3("R1 after release", rst_o, busy_o, done_o, 1'b0, 1'b0, 1'b0);

    // Table of requested widths and expected effective widths (R4)
    for (int i = 0; i < NVEC; i++) begin
      run_seq(VEC_REQ[i], VEC_EFF[i], -1, 1'b0, 1'b0, "R4 vec");
    end

    // R6 start during PRE, during HIGH1 and during GAP
    run_seq(120, 120, 4, 1'b0, 1'b0, "R6 pre");
    run_seq(110, 110, 40, 1'b0, 1'b0, "R6 high1");
    run_seq(115, 115, 10 + 115 + 5, 1'b0, 1'b0, "R6 gap");

    // R7 width change during the run (run_seq moves width_i every cycle)
    run_seq(130, 130, -1, 1'b0, 1'b0, "R7");

    // R8 back-to-back sequences
    run_seq(112, 112, -1, 1'b1, 1'b0, "R8 first");
    run_seq(112, 112, -1, 1'b0, 1'b1, "R8 second");

    // R9 asynchronous abort in the middle of the first pulse
    @(negedge clk);
    start_i = 1'b1;
    width_i = 16'd110;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    check3("R9 in pulse", rst_o, busy_o, done_o, 1'b1, 1'b1, 1'b0);
    #2 rst_n = 1'b0;
    #1 check3("R9 abort", rst_o, busy_o, done_o, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check3("R9 idle after", rst_o, busy_o, done_o, 1'b0, 1'b0, 1'b0);
    run_seq(110, 110, -1, 1'b0, 1'b0, "R9 rerun");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule